// File: doc/BRIEF.md
# Transactional MESI Line-State Controller

This block holds the coherence state of every line in a small direct-mapped L1 and moves each line through MESI extended with two speculative tagged states. A transactional store places a line in the speculatively modified tagged state (TMI), where its new value stays private to the core. Other cores may hold the same block in TMI at the same time. A transactional load whose fill reply is marked as threatened places the line in the tagged-invalid state (TI). In TI the fetched copy may be read inside the transaction, but it is never considered coherent.

Software ends a transaction with a one-cycle commit or abort pulse. Either pulse resolves every tagged line in the array at once, by clearing its tag bit and, on abort, its modified part. No addresses are walked and no bulk messages are sent. Lines in ordinary MESI states are not touched by either pulse.

The block models state only. Data arrays, directory behaviour and overflow storage sit elsewhere.

Top module: `tmesi_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every line reads state 3'b000 (I). The state encoding is {tag, mesi[1:0]}, with mesi I=0, S=1, E=2, M=3. So TMI=3'b111, TI=3'b100, M=3'b011, E=3'b010 and S=3'b001.
- R2: A request with op 3 (transactional store) moves the addressed line to TMI from any state. The update is seen one clock after the request.
- R3: A request with op 2 (transactional load) to a line in I moves it to TI when reply_threat_i is 1. When reply_threat_i is 0, it follows R4. On any other state, op 2 leaves the line unchanged.
- R4: A request with op 0 (plain load) to a line in I fills it to S when reply_shared_i is 1 and to E when it is 0. On any other state, op 0 leaves the line unchanged.
- R5: A request with op 1 (plain store) moves an untagged line to M. Ops 1 and 0 leave tagged lines unchanged, and ops 6 and 7 change nothing.
- R6: An op 4 request (remote read snoop) or op 5 request (remote write snoop) to a TMI line raises snp_threat_o with snp_data_o low. To an E or M line, such a request raises snp_data_o with snp_threat_o low. Op 4 turns E or M into S. Op 5 turns S, E or M into I. Tagged lines are unchanged by both snoops.
- R7: A commit pulse turns every TMI line into M and every TI line into I, all in the same clock.
- R8: An abort pulse turns every TMI and TI line into I in the same clock. Neither commit nor abort changes an untagged line.
- R9: When commit and abort are both high, only the abort takes effect.
- R10: In a cycle with commit or abort high, the request port is ignored. The addressed line is unchanged except by R7/R8, and both snoop outputs are low.
- R11: look_state_o shows the state of line look_idx_i combinationally. look_usable_o is 1 exactly when that state is not I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | Request op (0 load, 1 store, 2 tx load, 3 tx store, 4 remote read, 5 remote write) |
| req_idx_i | input | IDX_W | Line index of the request |
| reply_shared_i | input | 1 | Fill reply says another sharer exists |
| reply_threat_i | input | 1 | Fill reply says the block is transactionally written elsewhere |
| commit_i | input | 1 | Commit pulse |
| abort_i | input | 1 | Abort pulse |
| look_idx_i | input | IDX_W | Line index to observe |
| look_state_o | output | 3 | {tag, mesi} of the observed line |
| look_usable_o | output | 1 | Observed line holds usable data |
| snp_threat_o | output | 1 | Snoop answered with threat only |
| snp_data_o | output | 1 | Snoop answered with data |

## Verification
A wrong next-state value shows on look_state_o one clock after the request that caused it. A stale tag bit stays hidden until the next commit or abort. After that pulse it appears as an M line that should be I, or as a leftover tagged line on the next full-array read. The same wrong state corrupts snoop answers combinationally in the cycle a snoop reaches that line.

The bench therefore reads the target line after every request. It also reads the whole array after each commit or abort and at regular points in long random sequences. It compares each reading against a state model kept in the bench.

// File: rtl/tmesi_pkg.sv
package tmesi_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'd0,
    MESI_S = 2'd1,
    MESI_E = 2'd2,
    MESI_M = 2'd3
  } mesi_e;

  typedef enum logic [2:0] {
    OP_LD    = 3'd0,
    OP_ST    = 3'd1,
    OP_TLD   = 3'd2,
    OP_TST   = 3'd3,
    OP_SNPRD = 3'd4,
    OP_SNPWR = 3'd5,
    OP_NOP6  = 3'd6,
    OP_NOP7  = 3'd7
  } op_e;

  typedef struct packed {
    logic  t;
    mesi_e mesi;
  } line_st_t;

  localparam line_st_t ST_I   = '{t: 1'b0, mesi: MESI_I};
  localparam line_st_t ST_TMI = '{t: 1'b1, mesi: MESI_M};
  localparam line_st_t ST_TI  = '{t: 1'b1, mesi: MESI_I};
endpackage

// File: rtl/tmesi_next.sv
module tmesi_next
  import tmesi_pkg::*;
(
  input  line_st_t st_i,
  input  op_e      op_i,
  input  logic     shared_i,
  input  logic     threat_i,
  output line_st_t st_o
);
  line_st_t fill;

  always_comb begin
    fill = '{t: 1'b0, mesi: (shared_i ? MESI_S : MESI_E)};
    st_o = st_i;
    unique case (op_i)
      OP_LD:    if (st_i == ST_I) st_o = fill;
      OP_ST:    if (!st_i.t) st_o = '{t: 1'b0, mesi: MESI_M};
      OP_TLD:   if (st_i == ST_I) st_o = threat_i ? ST_TI : fill;
      OP_TST:   st_o = ST_TMI;
      OP_SNPRD: if (!st_i.t && (st_i.mesi == MESI_E || st_i.mesi == MESI_M))
                  st_o = '{t: 1'b0, mesi: MESI_S};
      OP_SNPWR: if (!st_i.t) st_o = ST_I;
      default:  st_o = st_i;
    endcase
  end
endmodule

// File: rtl/tmesi_line.sv
module tmesi_line
  import tmesi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_i,
  input  op_e      op_i,
  input  logic     shared_i,
  input  logic     threat_i,
  input  logic     commit_i,
  input  logic     abort_i,
  output line_st_t st_o
);
  line_st_t st_q, st_d, upd;

  tmesi_next u_next (
    .st_i    (st_q),
    .op_i    (op_i),
    .shared_i(shared_i),
    .threat_i(threat_i),
    .st_o    (upd)
  );

  // abort dominates commit; both mask the request port
  always_comb begin
    st_d = st_q;
    if (abort_i) begin
      if (st_q.t) st_d = ST_I;
    end else if (commit_i) begin
      st_d.t = 1'b0;
    end else if (sel_i) begin
      st_d = upd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_I;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  a_r2_tstore_to_tmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == OP_TST && !commit_i && !abort_i) |=> (st_q == ST_TMI));

  a_r7_commit_keeps_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !abort_i && st_q == ST_TMI) |=> (st_q.mesi == MESI_M && !st_q.t));

  a_r8_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && st_q.t) |=> (st_q == ST_I));

  a_r8_untagged_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((commit_i || abort_i) && !st_q.t) |=> $stable(st_q));

  a_r1_tag_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.t |-> (st_q.mesi == MESI_M || st_q.mesi == MESI_I));
endmodule

// File: rtl/tmesi_ctrl.sv
module tmesi_ctrl
  import tmesi_pkg::*;
#(
  parameter  int unsigned NLINES = 16,
  localparam int unsigned IDX_W  = $clog2(NLINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             reply_shared_i,
  input  logic             reply_threat_i,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic [2:0]       look_state_o,
  output logic             look_usable_o,
  output logic             snp_threat_o,
  output logic             snp_data_o
);
  line_st_t          st_arr [NLINES];
  logic [NLINES-1:0] t_vec;
  op_e               op;
  line_st_t          cur, look;
  logic              snoop, live;

  assign op = op_e'(req_op_i);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    tmesi_line u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (req_valid_i && (req_idx_i == IDX_W'(g))),
      .op_i    (op),
      .shared_i(reply_shared_i),
      .threat_i(reply_threat_i),
      .commit_i(commit_i),
      .abort_i (abort_i),
      .st_o    (st_arr[g])
    );
    assign t_vec[g] = st_arr[g].t;
  end

  assign cur   = st_arr[req_idx_i];
  assign look  = st_arr[look_idx_i];
  assign live  = req_valid_i && !commit_i && !abort_i;
  assign snoop = live && (op == OP_SNPRD || op == OP_SNPWR);

  assign snp_threat_o  = snoop && (cur == ST_TMI);
  assign snp_data_o    = snoop && !cur.t && (cur.mesi == MESI_E || cur.mesi == MESI_M);
  assign look_state_o  = look;
  assign look_usable_o = (look != ST_I);

  a_r9_abort_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (t_vec == '0));

  a_r7_commit_untags_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (t_vec == '0));

  a_r6_threat_excl_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_threat_o && snp_data_o));
endmodule

// File: tb/tb_tmesi_ctrl.sv
`timescale 1ns/10ps
module tb_tmesi_ctrl;
  localparam int N = 16;

  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, shared = 0, threat = 0, commit = 0, abort = 0;
  logic [2:0] req_op = 0;
  logic [3:0] req_idx = 0, look_idx = 0;
  logic [2:0] look_state;
  logic       look_usable, snp_threat, snp_data;

  int         n_chk = 0, n_fail = 0;
  logic [2:0] mdl [N];
  bit         done = 0;

  always #4 clk = ~clk;

  tmesi_ctrl #(.NLINES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_idx_i(req_idx), .reply_shared_i(shared), .reply_threat_i(threat),
    .commit_i(commit), .abort_i(abort), .look_idx_i(look_idx),
    .look_state_o(look_state), .look_usable_o(look_usable),
    .snp_threat_o(snp_threat), .snp_data_o(snp_data)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic logic [2:0] mnext(input logic [2:0] s, input logic [2:0] op,
                                       input logic sh, input logic th);
    case (op)
      3'd0: return (s == 3'd0) ? (sh ? 3'd1 : 3'd2) : s;
      3'd1: return s[2] ? s : 3'd3;
      3'd2: return (s == 3'd0) ? (th ? 3'd4 : (sh ? 3'd1 : 3'd2)) : s;
      3'd3: return 3'd7;
      3'd4: return (s == 3'd2 || s == 3'd3) ? 3'd1 : s;
      3'd5: return s[2] ? s : 3'd0;
      default: return s;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op, input bit cm, input bit ab);
    if (ab && cm) return "R9";
    if (ab) return "R8";
    if (cm) return "R10";
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R3";
      3'd3: return "R2";
      3'd4, 3'd5: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic full_check(input string r);
    for (int i = 0; i < N; i++) begin
      look_idx = 4'(i);
      #0.1;
      chk(r, look_state, mdl[i]);
      chk("R11", look_usable, (mdl[i] != 3'd0));
    end
  endtask

  task automatic cyc(input logic [2:0] op, input logic [3:0] idx, input bit v,
                     input bit sh, input bit th, input bit cm, input bit ab);
    bit et, ed;
    @(negedge clk);
    req_op = op; req_idx = idx; req_valid = v; shared = sh; threat = th;
    commit = cm; abort = ab;
    #1;
    et = v && !cm && !ab && (op == 3'd4 || op == 3'd5) && mdl[idx] == 3'd7;
    ed = v && !cm && !ab && (op == 3'd4 || op == 3'd5) && (mdl[idx] == 3'd2 || mdl[idx] == 3'd3);
    chk((cm || ab) ? "R10" : "R6", {snp_threat, snp_data}, {et, ed});
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (ab)      begin if (mdl[i][2]) mdl[i] = 3'd0; end
      else if (cm) mdl[i][2] = 1'b0;
      else if (v && idx == 4'(i)) mdl[i] = mnext(mdl[i], op, sh, th);
    end
    #1;
    req_valid = 0; commit = 0; abort = 0;
    look_idx = idx;
    #0.1;
    chk(tag(op, cm, ab), look_state, mdl[idx]);
  endtask

  task automatic setup(input int s, input logic [3:0] idx);
    cyc(3'd6, idx, 0, 0, 0, 0, 1);
    cyc(3'd5, idx, 1, 0, 0, 0, 0);
    case (s)
      1: cyc(3'd0, idx, 1, 1, 0, 0, 0);
      2: cyc(3'd0, idx, 1, 0, 0, 0, 0);
      3: cyc(3'd1, idx, 1, 0, 0, 0, 0);
      4: cyc(3'd2, idx, 1, 0, 1, 0, 0);
      5: cyc(3'd3, idx, 1, 0, 0, 0, 0);
      default: ;
    endcase
  endtask

  task automatic spread();
    for (int i = 0; i < N; i++) begin
      setup(i % 6, 4'(i));
      if (i % 6 == 5 && i + 1 < N) i++;
    end
    for (int i = 0; i < N; i += 3) cyc(3'd3, 4'(i), 1, 0, 0, 0, 0);
    cyc(3'd2, 4'd1, 1, 0, 1, 0, 0);
    cyc(3'd5, 4'd1, 1, 0, 0, 0, 0);
    cyc(3'd2, 4'd1, 1, 0, 1, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = 3'd0;
    #20;
    full_check("R1");
    @(negedge clk); rst_n = 1;
    full_check("R1");

    for (int s = 0; s < 6; s++)
      for (int op = 0; op < 8; op++)
        for (int f = 0; f < 4; f++) begin
          setup(s, 4'((s * 32 + op * 4 + f) % N));
          cyc(3'(op), 4'((s * 32 + op * 4 + f) % N), 1, f[0], f[1], 0, 0);
        end

    spread(); cyc(3'd6, 4'd0, 0, 0, 0, 1, 0); full_check("R7");
    spread(); cyc(3'd6, 4'd0, 0, 0, 0, 0, 1); full_check("R8");
    spread(); cyc(3'd6, 4'd0, 0, 0, 0, 1, 1); full_check("R9");
    spread(); cyc(3'd3, 4'd4, 1, 0, 0, 1, 0); full_check("R10");
    cyc(3'd1, 4'd1, 1, 0, 0, 0, 1); full_check("R10");
    spread(); cyc(3'd4, 4'd0, 1, 0, 0, 1, 0); full_check("R10");

    for (int k = 0; k < 4000; k++) begin
      cyc(3'($urandom % 8), 4'($urandom % N), ($urandom % 4) != 0,
          1'($urandom % 2), 1'($urandom % 2), ($urandom % 24) == 0, ($urandom % 30) == 0);
      if (k % 32 == 31) full_check("R11");
    end
    full_check("R11");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule